// File: doc/BRIEF.md
# Serial Two-Wire Data Byte Shifter

This block is the byte-wide data register of a two-wire serial port. A separate bit-level controller owns the clock line. It gives this block single-cycle strobes for each rising and falling edge of SCL, a transfer-direction select and a handshake flag. While the flag is high the port is idle between bytes. The CPU may then read the last byte seen on the bus and write the next byte to send. When the controller clears the flag, the block shifts one byte MSB first, followed by an acknowledge bit.

The data line is modelled as open drain. The block asserts a drive-low output and reads back the resolved line level. Every data bit is sampled back from the line, whether or not the block drove it, so after a byte the register holds what was really on the bus. This still holds when another master won the line partway through the byte. The acknowledge bit is driven or sampled by the block and reported on a separate status output. It never enters the CPU-visible register.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset the register reads 0xFF, the data line is released, `byte_done` is 0 and `ack_seen` is 0.
- R2: A CPU write (`cpu_wr` high) loads `cpu_wdata` only while `irq_flag` is high. A write while `irq_flag` is low leaves the register unchanged.
- R3: While `irq_flag` is high, SCL edge strobes have no effect on the register.
- R4: In transmit mode (`tx_mode` = 1) bits go out MSB first, with `sda_drive_low` = 1 for a 0 bit. The first bit appears one cycle after `irq_flag` falls, and each following bit appears one cycle after a `scl_fall` strobe.
- R5: Each of the first 8 `scl_rise` strobes of a byte shifts the register left and puts `sda_in` into bit 0. After 8 strobes the register holds the resolved bus byte, also when an outside device pulled bits low that this block released.
- R6: In receive mode (`tx_mode` = 0) the block never pulls the line low during the 8 data bits.
- R7: `byte_done` is high for exactly one cycle, the cycle after the 8th `scl_rise` of a byte.
- R8: After the `scl_fall` that follows the 8th rise, the block drives the line low only if `tx_mode` = 0 and `ack_enable` = 1. It releases the line after the `scl_fall` that follows the 9th rise. The acknowledge bit does not enter the register.
- R9: On the 9th `scl_rise`, `ack_seen` is set to 1 if `sda_in` is low and to 0 if it is high. It holds that value until the next acknowledge bit.
- R10: `scl_rise` strobes after the 9th one, until `irq_flag` is raised again, change neither the register nor `byte_done`.
- R11: While `irq_flag` is high, the line is released from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flag | input | 1 | High: port idle, CPU access allowed. Falling edge starts a byte |
| tx_mode | input | 1 | 1 = transmit byte, 0 = receive byte |
| ack_enable | input | 1 | Drive ACK low when receiving |
| scl_rise | input | 1 | One-cycle strobe per SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe per SCL falling edge |
| sda_in | input | 1 | Resolved data line level |
| sda_drive_low | output | 1 | Pull data line low |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register contents |
| byte_done | output | 1 | Pulse after 8th data bit |
| ack_seen | output | 1 | Last sampled acknowledge, 1 = ACK |

## Verification
On every cycle, the in-RTL assertions check the following. The register stays still while the flag is set and no write comes, and also while a byte is active and no rise strobe arrives. The bit counter stays in range and clears under the flag. `byte_done` only follows a rise strobe. The drive output changes only after a fall strobe, a transfer start or the flag. The line is released under the flag. Other behaviours need the bench's scenarios: the MSB-first bit order, the byte assembled after an arbitration-style conflict, the acknowledge polarity in each mode, and the discarded mid-byte write. Each of these depends on a whole sequence of strobes and on a model of the wired-AND bus.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;
  parameter int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/i2c_bit_phase.sv
module i2c_bit_phase #(
  parameter int unsigned W = i2c_shift_pkg::BYTE_W,
  localparam int unsigned CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_flag,
  input  logic          scl_rise,
  output logic [CW-1:0] cnt,
  output logic          in_data,
  output logic          in_ack,
  output logic          byte_done
);
  localparam logic [CW-1:0] LAST_DATA = CW'(W - 1);
  localparam logic [CW-1:0] ACK_SLOT  = CW'(W);
  localparam logic [CW-1:0] DONE_SLOT = CW'(W + 1);

  logic [CW-1:0] cnt_d;
  logic          done_d;

  always_comb begin
    cnt_d  = cnt;
    done_d = 1'b0;
    if (irq_flag) begin
      cnt_d = '0;
    end else if (scl_rise && (cnt <= ACK_SLOT)) begin
      cnt_d  = cnt + 1'b1;
      done_d = (cnt == LAST_DATA);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      byte_done <= 1'b0;
    end else begin
      cnt       <= cnt_d;
      byte_done <= done_d;
    end
  end

  assign in_data = (cnt < ACK_SLOT);
  assign in_ack  = (cnt == ACK_SLOT);

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DONE_SLOT);

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |=> (cnt == '0));

  // R7
  done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(scl_rise));
endmodule

// File: rtl/i2c_data_shreg.sv
module i2c_data_shreg #(
  parameter int unsigned W = i2c_shift_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_flag,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         scl_rise,
  input  logic         in_data,
  input  logic         sda_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (irq_flag) begin
      if (wr_en) q_d = wdata;
    end else if (scl_rise && in_data) begin
      q_d = {q[W-2:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_d;
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !wr_en) |=> $stable(q));

  // R2
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && !scl_rise) |=> $stable(q));
endmodule

// File: rtl/i2c_sda_drive.sv
module i2c_sda_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_flag,
  input  logic tx_mode,
  input  logic ack_enable,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic in_data,
  input  logic in_ack,
  input  logic msb,
  input  logic sda_in,
  output logic sda_drive_low,
  output logic ack_seen
);
  logic flag_q;
  logic start_evt;
  logic drive_d;
  logic ack_d;

  assign start_evt = flag_q && !irq_flag;

  always_comb begin
    drive_d = sda_drive_low;
    if (irq_flag) begin
      drive_d = 1'b0;
    end else if (start_evt) begin
      drive_d = tx_mode && !msb;
    end else if (scl_fall) begin
      if (in_data)     drive_d = tx_mode && !msb;
      else if (in_ack) drive_d = !tx_mode && ack_enable;
      else             drive_d = 1'b0;
    end
  end

  always_comb begin
    ack_d = ack_seen;
    if (!irq_flag && scl_rise && in_ack) ack_d = !sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q        <= 1'b1;
      sda_drive_low <= 1'b0;
      ack_seen      <= 1'b0;
    end else begin
      flag_q        <= irq_flag;
      sda_drive_low <= drive_d;
      ack_seen      <= ack_d;
    end
  end

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |=> !sda_drive_low);

  // R4
  drive_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> $past(scl_fall || start_evt || irq_flag));

  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && in_ack) |=> $stable(ack_seen));
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_flag,
  input  logic       tx_mode,
  input  logic       ack_enable,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       byte_done,
  output logic       ack_seen
);
  import i2c_shift_pkg::*;
  localparam int unsigned CW = $clog2(BYTE_W + 2);

  logic          rst_q;
  logic [CW-1:0] cnt;
  logic          in_data;
  logic          in_ack;
  byte_t         q;

  i2c_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  i2c_bit_phase #(.W(BYTE_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_q),
    .irq_flag  (irq_flag),
    .scl_rise  (scl_rise),
    .cnt       (cnt),
    .in_data   (in_data),
    .in_ack    (in_ack),
    .byte_done (byte_done)
  );

  i2c_data_shreg #(.W(BYTE_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_q),
    .irq_flag (irq_flag),
    .wr_en    (cpu_wr),
    .wdata    (cpu_wdata),
    .scl_rise (scl_rise),
    .in_data  (in_data),
    .sda_in   (sda_in),
    .q        (q)
  );

  i2c_sda_drive u_drive (
    .clk           (clk),
    .rst_n         (rst_q),
    .irq_flag      (irq_flag),
    .tx_mode       (tx_mode),
    .ack_enable    (ack_enable),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .in_data       (in_data),
    .in_ack        (in_ack),
    .msb           (q[BYTE_W-1]),
    .sda_in        (sda_in),
    .sda_drive_low (sda_drive_low),
    .ack_seen      (ack_seen)
  );

  assign cpu_rdata = q;

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_q)
    byte_done |=> !byte_done);
endmodule

// File: tb/i2c_byte_shifter_test.sv
module i2c_byte_shifter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_flag = 1'b1;
  logic tx_mode = 1'b0;
  logic ack_enable = 1'b0;
  logic scl_rise = 1'b0;
  logic scl_fall = 1'b0;
  logic ext_low = 1'b0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic sda_in;
  logic sda_drive_low;
  logic [7:0] cpu_rdata;
  logic byte_done;
  logic ack_seen;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  assign sda_in = ~(sda_drive_low | ext_low);

  i2c_byte_shifter uut (
    .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .tx_mode(tx_mode),
    .ack_enable(ack_enable), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .sda_drive_low(sda_drive_low), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .byte_done(byte_done),
    .ack_seen(ack_seen)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at every byte_done (R5, R7)
  always @(negedge clk) begin
    if (rst_n && byte_done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected byte_done actual=1 expected=0");
      end else begin
        string t;
        t = tag_q.pop_front();
        check(t, cpu_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic cpu_write(input logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic pulse_rise();
    scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_fall();
    scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0; @(negedge clk);
  endtask

  task automatic xfer(input bit tx, input logic [7:0] drv, input logic [7:0] ext,
                      input bit ack_en_i, input bit ext_ack, input bit poke, input string tag);
    logic [7:0] bus;
    logic own_ack;
    bus = (tx ? drv : 8'hFF) & ext;
    own_ack = !tx && ack_en_i;
    exp_q.push_back(bus);
    tag_q.push_back(tag);
    tx_mode = tx; ack_enable = ack_en_i;
    irq_flag = 1'b0;
    @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      ext_low = ~ext[i];
      @(negedge clk);
      if (tx) check("R4 drive bit", {7'd0, sda_drive_low}, {7'd0, ~drv[i]});
      else    check("R6 no drive in receive", {7'd0, sda_drive_low}, 8'd0);
      if (poke && i == 4) cpu_write(8'h00);
      pulse_rise();
      pulse_fall();
    end
    ext_low = ext_ack;
    @(negedge clk);
    check("R8 ack drive", {7'd0, sda_drive_low}, {7'd0, own_ack});
    pulse_rise();
    check("R9 ack sampled", {7'd0, ack_seen}, {7'd0, own_ack | ext_ack});
    check("R8 ack kept out of register", cpu_rdata, bus);
    pulse_fall();
    check("R8 ack release", {7'd0, sda_drive_low}, 8'd0);
    ext_low = 1'b0;
    pulse_rise();
    check("R10 extra rise ignored", cpu_rdata, bus);
    check("R9 ack held", {7'd0, ack_seen}, {7'd0, own_ack | ext_ack});
    irq_flag = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 released under flag", {7'd0, sda_drive_low}, 8'd0);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 register", cpu_rdata, 8'hFF);
    check("R1 drive", {7'd0, sda_drive_low}, 8'd0);
    check("R1 done", {7'd0, byte_done}, 8'd0);
    check("R1 ack", {7'd0, ack_seen}, 8'd0);

    // R2 write while flag high
    cpu_write(8'h6B);
    check("R2 write accepted", cpu_rdata, 8'h6B);
    // R3 strobes under the flag do nothing
    pulse_rise(); pulse_fall(); pulse_rise();
    check("R3 stable under flag", cpu_rdata, 8'h6B);
    check("R3 no byte_done", {7'd0, byte_done}, 8'd0);

    // R2 ignored write while flag low
    irq_flag = 1'b0; tx_mode = 1'b0;
    @(negedge clk);
    cpu_write(8'h12);
    check("R2 write ignored while busy", cpu_rdata, 8'h6B);
    irq_flag = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 transmit, slave acks, mid-byte write discarded (R2)
    cpu_write(8'hA5);
    xfer(1'b1, 8'hA5, 8'hFF, 1'b0, 1'b1, 1'b1, "R5 R2 tx byte");
    // R8 R9 receive with own ACK
    xfer(1'b0, 8'hFF, 8'h3C, 1'b1, 1'b0, 1'b0, "R5 R6 rx byte");
    // R9 receive without ACK
    xfer(1'b0, 8'hFF, 8'hC3, 1'b0, 1'b0, 1'b0, "R5 rx nack");
    // R9 transmit, NACK from far end
    cpu_write(8'h5A);
    xfer(1'b1, 8'h5A, 8'hFF, 1'b0, 1'b0, 1'b0, "R5 tx nack");
    // R5 conflict: outside device pulls bits low that this block releases
    cpu_write(8'hF0);
    xfer(1'b1, 8'hF0, 8'h9F, 1'b0, 1'b1, 1'b0, "R5 lost arbitration");

    repeat (4) @(negedge clk);
    check("R7 all bytes seen", 8'(exp_q.size()), 8'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule